// File: doc/BRIEF.md
# Message Timestamp Timer with Capture/Compare

This block keeps a 16-bit timebase for a message controller. The counter advances on a tick-enable pulse that is produced outside the block. Each transmitted or received message produces event pulses at the start and at the end of its frame. One of these two events, chosen by software, copies the counter into two capture registers. The synchronization capture register can be switched off. The timestamp capture register always loads.

Two compare registers watch the counter. A match sets a sticky interrupt flag and a matching status bit, and drives an interrupt output unless that flag's mask bit is set. Comparator 0 can also clear the counter, which turns it into a periodic timebase. A write to the preset register loads the counter directly. All registers are read and written as whole words over a simple bus. A write takes effect at the clock edge where it is presented. A read returns data combinationally for the address on the bus.

Top module: `msg_ts_timer`

## Requirements
- R1: After reset, every register reads 0x0000 and `irq_o` is low.
- R2: Capture register 0 (address 3) loads the counter on the selected frame event only while control bit 14 is 1. While that bit is 0 it keeps its value.
- R3: Capture register 1 (address 4) loads the counter on every selected frame event, whatever the control bits hold.
- R4: Control bit 13 selects the frame event for both capture registers: 0 uses `evt_sof_i` and 1 uses `evt_eof_i`. The event that is not selected is ignored.
- R5: A match occurs when a tick arrives while the counter equals a compare register. A match on compare 1 (address 6) sets flag bit 15, and a match on compare 0 (address 5) sets flag bit 14, in the flag register at address 7. Mask bits do not stop a flag from being set.
- R6: A compare register that holds 0x0000 never produces a match.
- R7: The status register (address 9, read-only) has bit 2 set with flag 15 and bit 1 set with flag 14. Each status bit clears when its flag is cleared.
- R8: `irq_o` is high exactly when flag 15 is 1 with mask bit 15 clear, or flag 14 is 1 with mask bit 14 clear. The mask register is at address 8.
- R9: A write to the preset register (address 2) loads the counter at that edge. The preset overrides both the tick increment and the clear.
- R10: Each tick adds one to the counter (address 1, read-only), and the counter wraps from 0xFFFF to 0x0000.
- R11: When control bit 11 is 1, a match on compare 0 loads 0 into the counter instead of the incremented value. A match on compare 1 never clears the counter.
- R12: Writing 1 to a flag bit clears it. A match in the same cycle as the clear keeps the flag set.
- R13: The control register is at address 0. The capture and compare registers read back whole words as written. Control keeps only bits 14, 13 and 11, and mask keeps only bits 15 and 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Counter tick enable |
| evt_sof_i | input | 1 | Frame-start event pulse |
| evt_eof_i | input | 1 | Frame-end event pulse |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| irq_o | output | 1 | Masked compare interrupt |

## Verification
Two pairs of functions can act in the same cycle. The first pair is a software flag clear and a compare match. The second pair is a preset write and the counter clear caused by comparator 0. The bench provokes each pair by holding the counter on the compare value and then issuing the bus write in the same cycle as the tick. For the first pair it expects flag 14 to remain set. For the second pair it expects the counter to hold the written preset, not zero and not the incremented value.

// File: rtl/msg_ts_pkg.sv
package msg_ts_pkg;
    // Register word addresses
    localparam int A_CTRL   = 0;
    localparam int A_COUNT  = 1;
    localparam int A_PRESET = 2;
    localparam int A_CAP0   = 3;
    localparam int A_CAP1   = 4;
    localparam int A_CMP0   = 5;
    localparam int A_CMP1   = 6;
    localparam int A_FLAG   = 7;
    localparam int A_MASK   = 8;
    localparam int A_STATUS = 9;

    // Control bits
    localparam int B_CAP0_EN = 14;
    localparam int B_CAP_SEL = 13;
    localparam int B_CLR_EN  = 11;

    // Flag / mask bits, status bits
    localparam int B_FLAG1 = 15;
    localparam int B_FLAG0 = 14;
    localparam int B_ST1   = 2;
    localparam int B_ST0   = 1;

    localparam int NUM_CMP = 2;
endpackage

// File: rtl/msg_ts_cmp.sv
module msg_ts_cmp #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] ref_i,
    input  logic             tick_i,
    output logic             hit_o
);
    // A zero compare value is treated as disabled
    assign hit_o = tick_i && (ref_i != '0) && (cnt_i == ref_i);
endmodule

// File: rtl/msg_ts_trig.sv
module msg_ts_trig (
    input  logic sof_i,
    input  logic eof_i,
    input  logic sel_i,
    output logic trig_o
);
    assign trig_o = sel_i ? eof_i : sof_i;
endmodule

// File: rtl/msg_ts_timer.sv
module msg_ts_timer
    import msg_ts_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              evt_sof_i,
    input  logic              evt_eof_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  wdata_i,
    output logic [CNT_W-1:0]  rdata_o,
    output logic              irq_o
);
    localparam logic [CNT_W-1:0] CTRL_KEEP =
        (CNT_W'(1) << B_CAP0_EN) | (CNT_W'(1) << B_CAP_SEL) | (CNT_W'(1) << B_CLR_EN);
    localparam logic [CNT_W-1:0] IRQ_KEEP =
        (CNT_W'(1) << B_FLAG1) | (CNT_W'(1) << B_FLAG0);

    typedef struct packed {
        logic [CNT_W-1:0]              ctrl;
        logic [CNT_W-1:0]              count;
        logic [CNT_W-1:0]              preset;
        logic [CNT_W-1:0]              cap0;
        logic [CNT_W-1:0]              cap1;
        logic [NUM_CMP-1:0][CNT_W-1:0] cmp;
        logic [CNT_W-1:0]              flag;
        logic [CNT_W-1:0]              mask;
        logic [CNT_W-1:0]              status;
    } ts_state_t;

    ts_state_t s_d, s_q;

    logic [NUM_CMP-1:0] hit;
    logic               trig;
    logic               preset_wr;
    logic [CNT_W-1:0]   flag_clr;

    // Comparators
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        msg_ts_cmp #(.CNT_W(CNT_W)) u_cmp (
            .cnt_i  (s_q.count),
            .ref_i  (s_q.cmp[g]),
            .tick_i (tick_i),
            .hit_o  (hit[g])
        );
    end

    msg_ts_trig u_trig (
        .sof_i  (evt_sof_i),
        .eof_i  (evt_eof_i),
        .sel_i  (s_q.ctrl[B_CAP_SEL]),
        .trig_o (trig)
    );

    assign preset_wr = wr_en_i && (addr_i == ADDR_W'(A_PRESET));
    assign flag_clr  = (wr_en_i && (addr_i == ADDR_W'(A_FLAG))) ? (wdata_i & IRQ_KEEP) : '0;

    always_comb begin
        s_d = s_q;

        // Bus writes
        if (wr_en_i) begin
            case (addr_i)
                ADDR_W'(A_CTRL):   s_d.ctrl   = wdata_i & CTRL_KEEP;
                ADDR_W'(A_PRESET): s_d.preset = wdata_i;
                ADDR_W'(A_CAP0):   s_d.cap0   = wdata_i;
                ADDR_W'(A_CAP1):   s_d.cap1   = wdata_i;
                ADDR_W'(A_CMP0):   s_d.cmp[0] = wdata_i;
                ADDR_W'(A_CMP1):   s_d.cmp[1] = wdata_i;
                ADDR_W'(A_MASK):   s_d.mask   = wdata_i & IRQ_KEEP;
                default: ;
            endcase
        end

        // Frame-event capture overrides a bus write in the same cycle
        if (trig && s_q.ctrl[B_CAP0_EN]) s_d.cap0 = s_q.count;
        if (trig)                        s_d.cap1 = s_q.count;

        // Counter: preset > clear-on-match > increment
        if (tick_i)                           s_d.count = s_q.count + 1'b1;
        if (hit[0] && s_q.ctrl[B_CLR_EN])     s_d.count = '0;
        if (preset_wr)                        s_d.count = wdata_i;

        // Flags and status: a match beats a same-cycle clear
        s_d.flag[B_FLAG1]   = hit[1] | (s_q.flag[B_FLAG1] & ~flag_clr[B_FLAG1]);
        s_d.flag[B_FLAG0]   = hit[0] | (s_q.flag[B_FLAG0] & ~flag_clr[B_FLAG0]);
        s_d.status[B_ST1]   = hit[1] | (s_q.status[B_ST1] & ~flag_clr[B_FLAG1]);
        s_d.status[B_ST0]   = hit[0] | (s_q.status[B_ST0] & ~flag_clr[B_FLAG0]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    always_comb begin
        case (addr_i)
            ADDR_W'(A_CTRL):   rdata_o = s_q.ctrl;
            ADDR_W'(A_COUNT):  rdata_o = s_q.count;
            ADDR_W'(A_PRESET): rdata_o = s_q.preset;
            ADDR_W'(A_CAP0):   rdata_o = s_q.cap0;
            ADDR_W'(A_CAP1):   rdata_o = s_q.cap1;
            ADDR_W'(A_CMP0):   rdata_o = s_q.cmp[0];
            ADDR_W'(A_CMP1):   rdata_o = s_q.cmp[1];
            ADDR_W'(A_FLAG):   rdata_o = s_q.flag;
            ADDR_W'(A_MASK):   rdata_o = s_q.mask;
            ADDR_W'(A_STATUS): rdata_o = s_q.status;
            default:           rdata_o = '0;
        endcase
    end

    assign irq_o = |(s_q.flag & ~s_q.mask & IRQ_KEEP);

    // Names visible to the bound checker
    logic [CNT_W-1:0] count_q, cap0_q, cap1_q, cmp0_q;
    logic             cap0_en_q, cap_sel_q, clr_en_q;
    logic             flag1_q, flag0_q, st1_q, st0_q, mask1_q, mask0_q;
    assign count_q   = s_q.count;
    assign cap0_q    = s_q.cap0;
    assign cap1_q    = s_q.cap1;
    assign cmp0_q    = s_q.cmp[0];
    assign cap0_en_q = s_q.ctrl[B_CAP0_EN];
    assign cap_sel_q = s_q.ctrl[B_CAP_SEL];
    assign clr_en_q  = s_q.ctrl[B_CLR_EN];
    assign flag1_q   = s_q.flag[B_FLAG1];
    assign flag0_q   = s_q.flag[B_FLAG0];
    assign st1_q     = s_q.status[B_ST1];
    assign st0_q     = s_q.status[B_ST0];
    assign mask1_q   = s_q.mask[B_FLAG1];
    assign mask0_q   = s_q.mask[B_FLAG0];
endmodule

// File: rtl/msg_ts_timer_chk.sv
module msg_ts_timer_chk
    import msg_ts_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tick_i,
    input logic              evt_sof_i,
    input logic              evt_eof_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [CNT_W-1:0]  wdata_i,
    input logic              irq_o,
    input logic [CNT_W-1:0]  count_q,
    input logic [CNT_W-1:0]  cap0_q,
    input logic [CNT_W-1:0]  cap1_q,
    input logic [CNT_W-1:0]  cmp0_q,
    input logic              cap0_en_q,
    input logic              cap_sel_q,
    input logic              clr_en_q,
    input logic              flag1_q,
    input logic              flag0_q,
    input logic              st1_q,
    input logic              st0_q,
    input logic              mask1_q,
    input logic              mask0_q
);
    logic evt_sel;
    logic pre_wr;
    assign evt_sel = cap_sel_q ? evt_eof_i : evt_sof_i;
    assign pre_wr  = wr_en_i && (addr_i == ADDR_W'(A_PRESET));

    assert_cap1_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_sel |=> cap1_q == $past(count_q));

    assert_cap0_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cap0_en_q && !(wr_en_i && addr_i == ADDR_W'(A_CAP0))) |=> $stable(cap0_q));

    assert_flag_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flag0_q) |-> ($past(tick_i) && $past(count_q) == $past(cmp0_q)));

    assert_zero_cmp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flag0_q) |-> $past(cmp0_q) != '0);

    assert_status_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st1_q == flag1_q) && (st0_q == flag0_q));

    assert_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask1_q && mask0_q) |-> !irq_o);

    assert_preset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pre_wr |=> count_q == $past(wdata_i));

    assert_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && count_q == '1 && !pre_wr && !(clr_en_q && cmp0_q == count_q))
        |=> count_q == '0);

    assert_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && clr_en_q && cmp0_q != '0 && count_q == cmp0_q && !pre_wr)
        |=> count_q == '0);
endmodule

bind msg_ts_timer msg_ts_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .evt_sof_i (evt_sof_i),
    .evt_eof_i (evt_eof_i),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .irq_o     (irq_o),
    .count_q   (count_q),
    .cap0_q    (cap0_q),
    .cap1_q    (cap1_q),
    .cmp0_q    (cmp0_q),
    .cap0_en_q (cap0_en_q),
    .cap_sel_q (cap_sel_q),
    .clr_en_q  (clr_en_q),
    .flag1_q   (flag1_q),
    .flag0_q   (flag0_q),
    .st1_q     (st1_q),
    .st0_q     (st0_q),
    .mask1_q   (mask1_q),
    .mask0_q   (mask0_q)
);

// File: tb/tb_msg_ts_timer.sv
`timescale 1ns/1ps
module tb_msg_ts_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        sof = 1'b0;
    logic        eof = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    msg_ts_timer dut (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .evt_sof_i(sof), .evt_eof_i(eof),
        .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
        end
    end

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [15:0] d, logic t = 1'b0);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; tick = t;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
        end
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic pulse(bit end_evt);
        @(negedge clk);
        if (end_evt) eof = 1'b1; else sof = 1'b1;
        @(negedge clk);
        sof = 1'b0; eof = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        for (int a = 0; a < 10; a++) begin
            rd(4'(a), v);
            check("R1 reset reg", v, 16'h0000);
        end
        check("R1 reset irq", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_rw();
        logic [15:0] v;
        wr(4'd3, 16'hBEEF); rd(4'd3, v); check("R13 cap0 rw", v, 16'hBEEF);
        wr(4'd6, 16'h1357); rd(4'd6, v); check("R13 cmp1 rw", v, 16'h1357);
        wr(4'd8, 16'hFFFF); rd(4'd8, v); check("R13 mask bits", v, 16'hC000);
        wr(4'd0, 16'hFFFF); rd(4'd0, v); check("R13 ctrl bits", v, 16'h6800);
        wr(4'd0, 16'h0000); wr(4'd8, 16'h0000); wr(4'd6, 16'h0000);
    endtask

    task automatic t_count();
        logic [15:0] v;
        wr(4'd2, 16'hFFFE); rd(4'd1, v); check("R9 preset load", v, 16'hFFFE);
        ticks(1); rd(4'd1, v); check("R10 increment", v, 16'hFFFF);
        ticks(1); rd(4'd1, v); check("R10 wrap", v, 16'h0000);
    endtask

    task automatic t_capture();
        logic [15:0] v;
        wr(4'd0, 16'h4000); wr(4'd2, 16'h1234); pulse(1'b0);
        rd(4'd3, v); check("R2 cap0 on sof", v, 16'h1234);
        rd(4'd4, v); check("R3 cap1 on sof", v, 16'h1234);
        wr(4'd2, 16'h2000); pulse(1'b1);
        rd(4'd3, v); check("R4 eof ignored cap0", v, 16'h1234);
        rd(4'd4, v); check("R4 eof ignored cap1", v, 16'h1234);
        wr(4'd0, 16'h6000); pulse(1'b1);
        rd(4'd3, v); check("R4 cap0 on eof", v, 16'h2000);
        rd(4'd4, v); check("R4 cap1 on eof", v, 16'h2000);
        pulse(1'b0);
        rd(4'd4, v); check("R4 sof ignored", v, 16'h2000);
        wr(4'd2, 16'h3000); wr(4'd0, 16'h2000); pulse(1'b1);
        rd(4'd3, v); check("R2 cap0 held", v, 16'h2000);
        rd(4'd4, v); check("R3 cap1 always", v, 16'h3000);
        wr(4'd0, 16'h0000);
    endtask

    task automatic t_compare();
        logic [15:0] v;
        wr(4'd5, 16'h0005); wr(4'd2, 16'h0003); ticks(2);
        rd(4'd7, v); check("R5 no early match", v, 16'h0000);
        ticks(1);
        rd(4'd7, v); check("R5 flag14", v, 16'h4000);
        rd(4'd9, v); check("R7 status1", v, 16'h0002);
        rd(4'd1, v); check("R11 no clear when bit11=0", v, 16'h0006);
        check("R8 irq unmasked", {15'd0, irq}, 16'h0001);
        wr(4'd8, 16'h4000);
        check("R8 irq masked", {15'd0, irq}, 16'h0000);
        rd(4'd7, v); check("R5 mask keeps flag", v, 16'h4000);
        wr(4'd7, 16'h4000);
        rd(4'd7, v); check("R12 w1c", v, 16'h0000);
        rd(4'd9, v); check("R7 status cleared", v, 16'h0000);
        wr(4'd8, 16'h0000); wr(4'd5, 16'h0000);
        wr(4'd6, 16'h0010); wr(4'd2, 16'h000F); ticks(2);
        rd(4'd7, v); check("R5 flag15", v, 16'h8000);
        rd(4'd9, v); check("R7 status2", v, 16'h0004);
        check("R8 irq from 15", {15'd0, irq}, 16'h0001);
        wr(4'd7, 16'h8000); wr(4'd6, 16'h0000);
    endtask

    task automatic t_zero();
        logic [15:0] v;
        wr(4'd2, 16'hFFFF); ticks(3);
        rd(4'd7, v); check("R6 zero cmp no match", v, 16'h0000);
        check("R6 irq low", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_clear();
        logic [15:0] v;
        wr(4'd0, 16'h0800); wr(4'd5, 16'h0004); wr(4'd2, 16'h0003); ticks(2);
        rd(4'd1, v); check("R11 clear on cmp0", v, 16'h0000);
        wr(4'd7, 16'h4000); wr(4'd5, 16'h0000);
        wr(4'd6, 16'h0004); wr(4'd2, 16'h0003); ticks(2);
        rd(4'd1, v); check("R11 cmp1 no clear", v, 16'h0005);
        wr(4'd7, 16'h8000); wr(4'd6, 16'h0000);
        wr(4'd5, 16'h0004); wr(4'd2, 16'h0004);
        wr(4'd2, 16'h0100, 1'b1);
        rd(4'd1, v); check("R9 preset beats clear", v, 16'h0100);
        wr(4'd7, 16'h4000); wr(4'd0, 16'h0000);
    endtask

    task automatic t_race();
        logic [15:0] v;
        wr(4'd5, 16'h0004); wr(4'd2, 16'h0004); ticks(1);
        wr(4'd2, 16'h0004);
        wr(4'd7, 16'h4000, 1'b1);
        rd(4'd7, v); check("R12 match beats clear", v, 16'h4000);
        wr(4'd7, 16'h4000);
        rd(4'd7, v); check("R12 clear after", v, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rw();
        t_count();
        t_capture();
        t_compare();
        t_zero();
        t_clear();
        t_race();
        done = 1'b1;
        summary();
    end
endmodule